// File: doc/BRIEF.md
# Coherent Measurement Register Bank with Bus-Idle Sleep Control

This block is the byte-wide register file that sits behind the memory-command layer of a single-wire slave. A command engine presents a byte address together with read and write strobes. It also raises a flag for as long as one read-data command lasts. A measurement core supplies a live signed 16-bit current value. It also delivers an accumulated current value with a load strobe. The bank keeps the accumulated value and hands it back to the core, so that host byte writes can adjust it.

Reading the high byte of either 16-bit quantity, while a read command is active, freezes both of its bytes. The host therefore sees one coherent pair even if the live value moves between the two byte reads. The freeze ends when the command flag drops.

Two control bits are held in a feature byte. One chooses which of two opcodes the read-network-address command answers to. The other permits a sleep request once the bus line has stayed low for a programmable number of timebase ticks.

Top module: `fuel_regbank`

## Requirements
- R1: After reset, rd_data is 0x00, sleep_req is 0, addr_read_opcode is 0x33 and acc_value is 0x0000.
- R2: A write to address 0x08 loads sleep-enable from wr_data bit 6 and opcode-select from wr_data bit 4. Reads of 0x01 and 0x08 return sleep-enable in bit 6, opcode-select in bit 4, and 0 in every other bit.
- R3: addr_read_opcode is 0x33 while opcode-select is 0 and 0x39 while it is 1.
- R4: Reads of any address other than 0x01, 0x08, 0x0E, 0x0F, 0x10 and 0x11 return 0x00. Writes to those other addresses, and to 0x01, 0x0E and 0x0F, change no readable state and no output.
- R5: rd_data is updated on the clock edge that samples rd_en, and holds its value otherwise.
- R6: While rd_cmd_active is 1, a read of 0x0E (current high byte) or 0x10 (accumulated high byte) captures both bytes of that quantity. Later reads of 0x0E/0x0F or 0x10/0x11 return the captured pair for the rest of the command. A repeated high-byte read does not recapture.
- R7: Once rd_cmd_active returns to 0, the capture is released. Reads outside a command, or of a low byte before its high byte was read in the command, return the live value.
- R8: An acc_valid pulse loads acc_in into acc_value. A write to 0x10 or 0x11 replaces only the high or low byte, takes priority over a same-cycle load for that byte, and leaves a held capture untouched.
- R9: A counter advances on each tick while bus_line is 0, saturates at LOW_TICKS and clears whenever bus_line is 1. sleep_req is 1 exactly when sleep-enable is 1 and the counter is at LOW_TICKS.
- R10: While sleep-enable is 0, sleep_req stays 0 however long the line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_cmd_active | input | 1 | High for the span of one read-data command |
| cur_in | input | 16 | Live signed current value |
| acc_in | input | 16 | Accumulated value from the measurement core |
| acc_valid | input | 1 | Loads acc_in into the held accumulated value |
| bus_line | input | 1 | Sampled level of the single-wire bus |
| tick | input | 1 | Timebase pulse for the bus-low counter |
| rd_data | output | 8 | Registered read byte |
| acc_value | output | 16 | Held accumulated value, including host byte writes |
| sleep_req | output | 1 | Sleep request after a long bus-low period |
| addr_read_opcode | output | 8 | Opcode selected for the read-network-address command |

## Verification
The bound checker watches several rules on every cycle. The opcode must always be one of the two legal values and must follow each feature write. Reserved reads must return zero, and a status-address write must leave the control bits alone. A held capture must stay frozen while the command lasts and must be released once the flag drops. A sleep request must only occur with sleep enabled and after a low line.

Some behaviours are only visible across a sequence, so only the bench's scenarios can show them. These include the exact tick count at which sleep asserts, the counter clearing on a high glitch, and the coherence of a byte pair whose live value changes between reads. The same holds for write priority over a same-cycle accumulated load, and for a write during a capture that reaches acc_value but not the held pair.

// File: rtl/fgr_pkg.sv
package fgr_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    localparam logic [7:0] ADDR_STATUS  = 8'h01;
    localparam logic [7:0] ADDR_FEATURE = 8'h08;
    localparam logic [7:0] ADDR_CUR_HI  = 8'h0E;
    localparam logic [7:0] ADDR_CUR_LO  = 8'h0F;
    localparam logic [7:0] ADDR_ACC_HI  = 8'h10;
    localparam logic [7:0] ADDR_ACC_LO  = 8'h11;

    localparam int BIT_SLEEP_EN = 6;
    localparam int BIT_OPSEL    = 4;

    localparam logic [7:0] OPC_PRIMARY = 8'h33;
    localparam logic [7:0] OPC_ALT     = 8'h39;

    localparam int NUM_PAIRS = 2;
    localparam int PAIR_CUR  = 0;
    localparam int PAIR_ACC  = 1;

    typedef struct packed {
        logic [BYTE_W-1:0] rd_data;
        logic              sleep_en;
        logic              opsel;
        logic [WORD_W-1:0] acc;
    } bank_state_t;
endpackage

// File: rtl/fgr_snap_pair.sv
module fgr_snap_pair #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] live,
    input  logic         capture,
    input  logic         rel,
    output logic         held,
    output logic [W-1:0] value
);
    typedef struct packed {
        logic         held;
        logic [W-1:0] val;
    } snap_t;

    snap_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rel) begin
            s_d.held = 1'b0;
        end else if (capture && !s_q.held) begin
            s_d.held = 1'b1;
            s_d.val  = live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign held  = s_q.held;
    assign value = s_q.val;
endmodule

// File: rtl/fgr_low_timer.sv
module fgr_low_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (line)                     cnt_d = '0;
        else if (tick && cnt_q != LIM) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LIM);
endmodule

// File: rtl/fuel_regbank.sv
module fuel_regbank
    import fgr_pkg::*;
#(
    parameter int LOW_TICKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_cmd_active,
    input  logic [WORD_W-1:0] cur_in,
    input  logic [WORD_W-1:0] acc_in,
    input  logic              acc_valid,
    input  logic              bus_line,
    input  logic              tick,
    output logic [BYTE_W-1:0] rd_data,
    output logic [WORD_W-1:0] acc_value,
    output logic              sleep_req,
    output logic [7:0]        addr_read_opcode
);
    localparam logic [NUM_PAIRS-1:0][7:0] HI_ADDR = {ADDR_ACC_HI, ADDR_CUR_HI};

    bank_state_t q, d;

    logic [NUM_PAIRS-1:0][WORD_W-1:0] live;
    logic [NUM_PAIRS-1:0][WORD_W-1:0] snap_val;
    logic [NUM_PAIRS-1:0][WORD_W-1:0] shown;
    logic [NUM_PAIRS-1:0]             held;
    logic                             low_expired;

    assign live[PAIR_CUR] = cur_in;
    assign live[PAIR_ACC] = q.acc;

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        logic cap;
        assign cap = rd_en && rd_cmd_active && (addr == HI_ADDR[i]);
        fgr_snap_pair #(.W(WORD_W)) u_snap (
            .clk     (clk),
            .rst_n   (rst_n),
            .live    (live[i]),
            .capture (cap),
            .rel     (!rd_cmd_active),
            .held    (held[i]),
            .value   (snap_val[i])
        );
        assign shown[i] = held[i] ? snap_val[i] : live[i];
    end

    fgr_low_timer #(.LIMIT(LOW_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .line    (bus_line),
        .tick    (tick),
        .expired (low_expired)
    );

    logic [BYTE_W-1:0] ctrl_byte;
    logic [BYTE_W-1:0] rd_mux;

    always_comb begin
        ctrl_byte               = '0;
        ctrl_byte[BIT_SLEEP_EN] = q.sleep_en;
        ctrl_byte[BIT_OPSEL]    = q.opsel;
    end

    always_comb begin
        unique case (addr)
            ADDR_STATUS, ADDR_FEATURE: rd_mux = ctrl_byte;
            ADDR_CUR_HI: rd_mux = shown[PAIR_CUR][WORD_W-1:BYTE_W];
            ADDR_CUR_LO: rd_mux = shown[PAIR_CUR][BYTE_W-1:0];
            ADDR_ACC_HI: rd_mux = shown[PAIR_ACC][WORD_W-1:BYTE_W];
            ADDR_ACC_LO: rd_mux = shown[PAIR_ACC][BYTE_W-1:0];
            default:     rd_mux = '0;
        endcase
    end

    always_comb begin
        d = q;
        if (acc_valid) d.acc = acc_in;
        if (wr_en) begin
            unique case (addr)
                ADDR_FEATURE: begin
                    d.sleep_en = wr_data[BIT_SLEEP_EN];
                    d.opsel    = wr_data[BIT_OPSEL];
                end
                ADDR_ACC_HI: d.acc[WORD_W-1:BYTE_W] = wr_data;
                ADDR_ACC_LO: d.acc[BYTE_W-1:0]      = wr_data;
                default: ;
            endcase
        end
        if (rd_en) d.rd_data = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data          = q.rd_data;
    assign acc_value        = q.acc;
    assign sleep_req        = q.sleep_en && low_expired;
    assign addr_read_opcode = q.opsel ? OPC_ALT : OPC_PRIMARY;
endmodule

// File: rtl/fgr_regbank_chk.sv
module fgr_regbank_chk
    import fgr_pkg::*;
(
    input logic                             clk,
    input logic                             rst_n,
    input logic [7:0]                       addr,
    input logic                             rd_en,
    input logic                             wr_en,
    input logic [BYTE_W-1:0]                wr_data,
    input logic                             rd_cmd_active,
    input logic                             bus_line,
    input logic [BYTE_W-1:0]                rd_data,
    input logic                             sleep_req,
    input logic [7:0]                       opcode,
    input logic                             sleep_en,
    input logic                             opsel,
    input logic [NUM_PAIRS-1:0]             held,
    input logic [NUM_PAIRS-1:0][WORD_W-1:0] snap_val
);
    logic reserved_addr;
    assign reserved_addr = !(addr inside {8'h01, 8'h08, 8'h0E, 8'h0F, 8'h10, 8'h11});

    assert_opcode_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 8'h33) || (opcode == 8'h39));

    assert_opcode_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h08) |=> (opcode == ($past(wr_data[4]) ? 8'h39 : 8'h33)));

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reserved_addr) |=> (rd_data == 8'h00));

    assert_status_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h01) |=> ($stable(sleep_en) && $stable(opsel)));

    assert_cur_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (held[0] && rd_cmd_active) |=> (held[0] && $stable(snap_val[0])));

    assert_acc_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (held[1] && rd_cmd_active) |=> (held[1] && $stable(snap_val[1])));

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cmd_active |=> (held == '0));

    assert_sleep_after_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> $past(!bus_line));

    assert_sleep_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_en |-> !sleep_req);
endmodule

bind fuel_regbank fgr_regbank_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr          (addr),
    .rd_en         (rd_en),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_cmd_active (rd_cmd_active),
    .bus_line      (bus_line),
    .rd_data       (rd_data),
    .sleep_req     (sleep_req),
    .opcode        (addr_read_opcode),
    .sleep_en      (q.sleep_en),
    .opsel         (q.opsel),
    .held          (held),
    .snap_val      (snap_val)
);

// File: tb/sim_fuel_regbank.sv
module sim_fuel_regbank;
    localparam int LT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_cmd_active = 1'b0;
    logic [15:0] cur_in = '0, acc_in = '0;
    logic        acc_valid = 1'b0;
    logic        bus_line = 1'b1;
    logic        tick = 1'b0;
    logic [7:0]  rd_data;
    logic [15:0] acc_value;
    logic        sleep_req;
    logic [7:0]  addr_read_opcode;

    int checks = 0;
    int failures = 0;

    logic [15:0] acc_m = '0;
    logic        sen_m = 1'b0, osel_m = 1'b0;

    always #4 clk = ~clk;

    fuel_regbank #(.LOW_TICKS(LT)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_cmd_active(rd_cmd_active), .cur_in(cur_in),
        .acc_in(acc_in), .acc_valid(acc_valid), .bus_line(bus_line), .tick(tick),
        .rd_data(rd_data), .acc_value(acc_value), .sleep_req(sleep_req),
        .addr_read_opcode(addr_read_opcode)
    );

    function automatic logic [7:0] ctrl_exp();
        return {1'b0, sen_m, 1'b0, osel_m, 4'b0000};
    endfunction

    function automatic logic [7:0] opc_exp();
        return osel_m ? 8'h39 : 8'h33;
    endfunction

    function automatic logic is_mapped(input logic [7:0] a);
        return a inside {8'h01, 8'h08, 8'h0E, 8'h0F, 8'h10, 8'h11};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] dout);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; dout = rd_data;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk); addr = a; wr_data = v; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        if (a == 8'h08) begin sen_m = v[6]; osel_m = v[4]; end
        if (a == 8'h10) acc_m[15:8] = v;
        if (a == 8'h11) acc_m[7:0] = v;
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] a_val, c_val, d_val;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", {8'h0, rd_data}, 16'h0);
        chk("R1 sleep_req", {15'h0, sleep_req}, 16'h0);
        chk("R1 opcode", {8'h0, addr_read_opcode}, 16'h33);
        chk("R1 acc_value", acc_value, 16'h0);

        // R2 R3 feature byte and opcode selection
        for (int i = 0; i < 10; i++) begin
            wr(8'h08, 8'($urandom));
            rd(8'h01, b); chk("R2 status read", {8'h0, b}, {8'h0, ctrl_exp()});
            rd(8'h08, b); chk("R2 feature read", {8'h0, b}, {8'h0, ctrl_exp()});
            chk("R3 opcode", {8'h0, addr_read_opcode}, {8'h0, opc_exp()});
        end
        wr(8'h08, 8'h10);
        chk("R3 opcode alt", {8'h0, addr_read_opcode}, 16'h39);
        wr(8'h08, 8'hEF);
        chk("R3 opcode primary", {8'h0, addr_read_opcode}, 16'h33);

        // R4 writes to read-only status ignored
        wr(8'h08, 8'h50);
        @(negedge clk); addr = 8'h01; wr_data = 8'h00; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        rd(8'h01, b); chk("R4 status write ignored", {8'h0, b}, 16'h50);
        chk("R4 opcode unchanged", {8'h0, addr_read_opcode}, 16'h39);
        wr(8'h08, 8'h00);

        // R4 writes to current bytes ignored
        cur_in = 16'hA55A;
        @(negedge clk); addr = 8'h0E; wr_data = 8'h12; wr_en = 1'b1;
        @(negedge clk); addr = 8'h0F; wr_data = 8'h34;
        @(negedge clk); wr_en = 1'b0;
        rd(8'h0E, b); chk("R4 cur hi after write", {8'h0, b}, 16'hA5);
        rd(8'h0F, b); chk("R4 cur lo after write", {8'h0, b}, 16'h5A);

        // R4 reserved addresses
        for (int i = 0; i < 24; i++) begin
            logic [7:0] ra;
            ra = 8'($urandom);
            if (is_mapped(ra)) ra = 8'h00;
            @(negedge clk); addr = ra; wr_data = 8'hFF; wr_en = 1'b1;
            @(negedge clk); wr_en = 1'b0;
            rd(ra, b); chk("R4 reserved read", {8'h0, b}, 16'h0);
        end
        rd(8'h08, b); chk("R4 reserved write no ctrl effect", {8'h0, b}, {8'h0, ctrl_exp()});
        chk("R4 reserved write no acc effect", acc_value, acc_m);

        // R5 rd_data holds without a read strobe
        rd(8'h0E, b);
        cur_in = 16'h0102;
        repeat (3) @(negedge clk);
        chk("R5 rd_data holds", {8'h0, rd_data}, {8'h0, b});

        // R8 accumulated load and byte writes
        a_val = 16'($urandom);
        @(negedge clk); acc_in = a_val; acc_valid = 1'b1;
        @(negedge clk); acc_valid = 1'b0; acc_m = a_val;
        chk("R8 acc load", acc_value, acc_m);
        wr(8'h10, 8'hC3); chk("R8 acc hi write", acc_value, acc_m);
        wr(8'h11, 8'h3C); chk("R8 acc lo write", acc_value, acc_m);
        @(negedge clk); acc_in = 16'h7788; acc_valid = 1'b1;
        addr = 8'h11; wr_data = 8'hEE; wr_en = 1'b1;
        @(negedge clk); acc_valid = 1'b0; wr_en = 1'b0; acc_m = 16'h77EE;
        chk("R8 write beats load", acc_value, 16'h77EE);

        // R6 R7 current snapshot
        c_val = 16'h1234;
        cur_in = c_val;
        @(negedge clk); rd_cmd_active = 1'b1;
        rd(8'h0F, b); chk("R7 lo before hi is live", {8'h0, b}, 16'h34);
        rd(8'h0E, b); chk("R6 cur hi captured", {8'h0, b}, 16'h12);
        cur_in = 16'hABCD;
        rd(8'h0F, b); chk("R6 cur lo from capture", {8'h0, b}, 16'h34);
        cur_in = 16'h5E6F;
        rd(8'h0E, b); chk("R6 no recapture", {8'h0, b}, 16'h12);
        @(negedge clk); rd_cmd_active = 1'b0;
        rd(8'h0F, b); chk("R7 released lo live", {8'h0, b}, 16'h6F);
        @(negedge clk); rd_cmd_active = 1'b1;
        rd(8'h0E, b); chk("R7 fresh capture", {8'h0, b}, 16'h5E);
        @(negedge clk); rd_cmd_active = 1'b0;

        // R6 R8 accumulated snapshot with write during hold
        d_val = acc_m;
        @(negedge clk); rd_cmd_active = 1'b1;
        rd(8'h10, b); chk("R6 acc hi captured", {8'h0, b}, {8'h0, d_val[15:8]});
        wr(8'h11, 8'h99);
        chk("R8 acc write during hold", acc_value, acc_m);
        rd(8'h11, b); chk("R8 snapshot undisturbed", {8'h0, b}, {8'h0, d_val[7:0]});
        @(negedge clk); rd_cmd_active = 1'b0;
        rd(8'h11, b); chk("R7 acc lo live after release", {8'h0, b}, 16'h99);

        // R9 bus-low timer
        wr(8'h08, 8'h40);
        @(negedge clk); bus_line = 1'b0;
        pulse_tick(LT - 1);
        chk("R9 one tick short", {15'h0, sleep_req}, 16'h0);
        pulse_tick(1);
        chk("R9 asserted at limit", {15'h0, sleep_req}, 16'h1);
        pulse_tick(3);
        chk("R9 saturated", {15'h0, sleep_req}, 16'h1);
        @(negedge clk); bus_line = 1'b1;
        @(negedge clk);
        chk("R9 cleared by high line", {15'h0, sleep_req}, 16'h0);
        bus_line = 1'b0;
        pulse_tick(5);
        @(negedge clk); bus_line = 1'b1;
        @(negedge clk); bus_line = 1'b0;
        pulse_tick(LT - 1);
        chk("R9 glitch restarts count", {15'h0, sleep_req}, 16'h0);
        @(negedge clk); bus_line = 1'b1;

        // R10 sleep disabled
        wr(8'h08, 8'h00);
        @(negedge clk); bus_line = 1'b0;
        pulse_tick(LT + 4);
        chk("R10 no sleep when disabled", {15'h0, sleep_req}, 16'h0);
        wr(8'h08, 8'h40);
        chk("R9 enable with count at limit", {15'h0, sleep_req}, 16'h1);
        @(negedge clk); bus_line = 1'b1;
        wr(8'h08, 8'h00);

        // R7 random live reads outside a command
        for (int i = 0; i < 200; i++) begin
            logic [7:0] sel;
            logic [7:0] e;
            cur_in = 16'($urandom);
            case ($urandom % 5)
                0: sel = 8'h0E;
                1: sel = 8'h0F;
                2: sel = 8'h10;
                3: sel = 8'h11;
                default: sel = 8'h01;
            endcase
            case (sel)
                8'h0E: e = cur_in[15:8];
                8'h0F: e = cur_in[7:0];
                8'h10: e = acc_m[15:8];
                8'h11: e = acc_m[7:0];
                default: e = ctrl_exp();
            endcase
            rd(sel, b);
            chk("R7 random live read", {8'h0, b}, {8'h0, e});
        end

        finish_run();
    end
endmodule